// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Almost-Empty and Almost-Full Flags

This block is a first-in first-out buffer between two unrelated clock domains. A producer writes 9-bit words on the write clock and a consumer takes them out on the read clock. Four active-low flags report the fill level: empty, full, almost-empty and almost-full. The two "almost" flags fire at thresholds that software sets. Each side computes its own flags from its own pointer and a synchronised copy of the other side's pointer, so each flag changes only on the clock of the side that acts on it.

The two thresholds are the empty offset n and the full offset m. Both are held in the block and go in and out over the ordinary data ports. While the load control is low, write cycles deposit data-bus fields into the threshold registers rather than into the queue. In the same mode, read cycles present those registers on the output bus. Each threshold is split into a low part and a high part. A small rotating selector, one on each side, walks through the four parts. The depth is a parameter; the default of 32 words keeps simulation short.

Top module: `prog_flag_fifo`

## Requirements
- R1: After reset, empty_n and pae_n are 0, full_n and paf_n are 1, both thresholds are zero, and both part selectors point at the empty-offset low part.
- R2: With ld_n high, each rising rclk edge that sees ren_n low and empty_n high takes the oldest word, and it is on dout right after that edge. Words leave in the order they were written.
- R3: A write attempted while full_n is low is dropped: full_n stays low and the dropped word is never read out.
- R4: A read attempted while empty_n is low is dropped: dout keeps its value and no word is lost.
- R5: Once both pointers have crossed, full_n is low exactly when DEPTH words are unread.
- R6: After a word is written into an empty FIFO, empty_n is still low at the next rclk edge. The word can only be taken after empty_n has gone high.
- R7: With ld_n low and wen_n low, each rising wclk edge stores one field and adds nothing to the queue. The fields are taken in this order: empty-offset low part (din[2:0] into n[2:0]), empty-offset high part (din[1:0] into n[4:3]), full-offset low part (din[2:0] into m[2:0]), full-offset high part (din[1:0] into m[4:3]). After the fourth field the write selector returns to the first.
- R8: With ld_n low and ren_n low, each rising rclk edge puts the next part, in the same order as R7 and zero-extended, on dout. The read selector is separate from the write selector and also wraps after four.
- R9: paf_n is low when the unread count is at least DEPTH - m, and it goes back high once the free space exceeds m.
- R10: pae_n is low when the unread count is at most n, and high when the count is above n.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wclk | input | 1 | Write-side clock |
| rclk | input | 1 | Read-side clock |
| rst_n | input | 1 | Asynchronous active-low reset for both sides |
| wen_n | input | 1 | Write enable, active low |
| ren_n | input | 1 | Read enable, active low |
| ld_n | input | 1 | Low selects the threshold registers instead of the queue |
| din | input | DATA_W | Write data, or threshold field in load mode |
| dout | output | DATA_W | Read data, or threshold part in load mode |
| empty_n | output | 1 | Low when no word is available (read domain) |
| full_n | output | 1 | Low when no space is left (write domain) |
| pae_n | output | 1 | Low when the unread count is at most n (read domain) |
| paf_n | output | 1 | Low when the unread count is at least DEPTH - m (write domain) |

## Verification
The first pattern fills the queue one word at a time and then drains it one word at a time, settling after each step. This checks every flag at every fill level from 0 to DEPTH, so an off-by-one error in either threshold comparison shows up. Two concurrent streams follow. In one, the reader takes a word only every third cycle, which keeps the writer pressed against full. In the other, the writer idles every other cycle, which keeps the reader working at the empty edge. Together they separate back-pressure faults from underflow faults. The threshold registers are loaded with eight writes, so the pattern proves the write selector wraps. They are then read back eight times, which does the same for the read selector.

// File: rtl/fifo_flag_pkg.sv
`timescale 1ns/1ps
package fifo_flag_pkg;

    // Order in which the four threshold parts are visited in load mode.
    typedef enum logic [1:0] {
        OFS_AE_LO = 2'd0,
        OFS_AE_HI = 2'd1,
        OFS_AF_LO = 2'd2,
        OFS_AF_HI = 2'd3
    } ofs_sel_e;

endpackage

// File: rtl/fifo_sync.sv
`timescale 1ns/1ps
module fifo_sync #(
    parameter int W      = 6,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stage_q[s] <= '0;
            end else if (s == 0) begin
                stage_q[s] <= d;
            end else begin
                stage_q[s] <= stage_q[(s > 0) ? s - 1 : 0];
            end
        end
    end

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/fifo_ram.sv
`timescale 1ns/1ps
module fifo_ram #(
    parameter int AW = 5,
    parameter int DW = 9
) (
    input  logic          wclk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] store [DEPTH];

    always_ff @(posedge wclk) begin
        if (we) begin
            store[waddr] <= wdata;
        end
    end

    assign rdata = store[raddr];
endmodule

// File: rtl/fifo_wr_ctl.sv
`timescale 1ns/1ps
module fifo_wr_ctl
    import fifo_flag_pkg::*;
#(
    parameter int AW   = 5,
    parameter int DW   = 9,
    parameter int LO_W = 3
) (
    input  logic          wclk,
    input  logic          rst_n,
    input  logic          wen_n,
    input  logic          ld_n,
    input  logic [DW-1:0] din,
    input  logic [AW:0]   rgray_s,
    output logic          mem_we,
    output logic [AW-1:0] mem_waddr,
    output logic [AW:0]   wgray,
    output logic          full,
    output logic          paf,
    output logic [AW-1:0] ae_ofs,
    output logic [AW-1:0] af_ofs
);
    localparam int          HI_W    = AW - LO_W;
    localparam int          DEPTH   = 1 << AW;
    localparam logic [AW:0] DEPTH_V = DEPTH[AW:0];

    typedef struct packed {
        logic [AW:0]   wbin;
        logic [AW:0]   wgray;
        logic          full;
        logic          paf;
        ofs_sel_e      sel;
        logic [AW-1:0] ae_ofs;
        logic [AW-1:0] af_ofs;
    } wr_state_t;

    localparam wr_state_t WR_RST = '0;

    function automatic logic [AW:0] gray2bin(input logic [AW:0] g);
        logic [AW:0] b;
        b[AW] = g[AW];
        for (int i = AW - 1; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

    wr_state_t   s_d, s_q;
    logic        push, load;
    logic [AW:0] rbin, used;

    always_comb begin
        s_d  = s_q;
        load = ~ld_n & ~wen_n;
        push = ld_n & ~wen_n & ~s_q.full;

        s_d.wbin  = s_q.wbin + {{AW{1'b0}}, push};
        s_d.wgray = (s_d.wbin >> 1) ^ s_d.wbin;

        rbin     = gray2bin(rgray_s);
        used     = s_d.wbin - rbin;
        s_d.full = (s_d.wgray == {~rgray_s[AW:AW-1], rgray_s[AW-2:0]});
        s_d.paf  = (used >= (DEPTH_V - {1'b0, s_q.af_ofs}));

        if (load) begin
            case (s_q.sel)
                OFS_AE_LO: s_d.ae_ofs[LO_W-1:0] = din[LO_W-1:0];
                OFS_AE_HI: s_d.ae_ofs[AW-1:LO_W] = din[HI_W-1:0];
                OFS_AF_LO: s_d.af_ofs[LO_W-1:0] = din[LO_W-1:0];
                default:   s_d.af_ofs[AW-1:LO_W] = din[HI_W-1:0];
            endcase
            s_d.sel = ofs_sel_e'(s_q.sel + 2'd1);
        end
    end

    always_ff @(posedge wclk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= WR_RST;
        end else begin
            s_q <= s_d;
        end
    end

    assign mem_we    = push;
    assign mem_waddr = s_q.wbin[AW-1:0];
    assign wgray     = s_q.wgray;
    assign full      = s_q.full;
    assign paf       = s_q.paf;
    assign ae_ofs    = s_q.ae_ofs;
    assign af_ofs    = s_q.af_ofs;
endmodule

// File: rtl/fifo_rd_ctl.sv
`timescale 1ns/1ps
module fifo_rd_ctl
    import fifo_flag_pkg::*;
#(
    parameter int AW   = 5,
    parameter int DW   = 9,
    parameter int LO_W = 3
) (
    input  logic          rclk,
    input  logic          rst_n,
    input  logic          ren_n,
    input  logic          ld_n,
    input  logic [AW:0]   wgray_s,
    input  logic [DW-1:0] mem_rdata,
    input  logic [AW-1:0] ae_ofs,
    input  logic [AW-1:0] af_ofs,
    output logic [AW-1:0] mem_raddr,
    output logic [AW:0]   rgray,
    output logic          empty,
    output logic          pae,
    output logic [DW-1:0] dout
);
    localparam int HI_W = AW - LO_W;

    typedef struct packed {
        logic [AW:0]   rbin;
        logic [AW:0]   rgray;
        logic          empty;
        logic          pae;
        ofs_sel_e      sel;
        logic [DW-1:0] dout;
    } rd_state_t;

    localparam rd_state_t RD_RST = '{
        rbin:  '0,
        rgray: '0,
        empty: 1'b1,
        pae:   1'b1,
        sel:   OFS_AE_LO,
        dout:  '0
    };

    function automatic logic [AW:0] gray2bin(input logic [AW:0] g);
        logic [AW:0] b;
        b[AW] = g[AW];
        for (int i = AW - 1; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

    rd_state_t   s_d, s_q;
    logic        fetch, peek;
    logic [AW:0] wbin, used;

    always_comb begin
        s_d   = s_q;
        fetch = ld_n & ~ren_n & ~s_q.empty;
        peek  = ~ld_n & ~ren_n;

        s_d.rbin  = s_q.rbin + {{AW{1'b0}}, fetch};
        s_d.rgray = (s_d.rbin >> 1) ^ s_d.rbin;

        wbin      = gray2bin(wgray_s);
        used      = wbin - s_d.rbin;
        s_d.empty = (s_d.rgray == wgray_s);
        s_d.pae   = (used <= {1'b0, ae_ofs});

        if (fetch) begin
            s_d.dout = mem_rdata;
        end else if (peek) begin
            s_d.dout = '0;
            case (s_q.sel)
                OFS_AE_LO: s_d.dout[LO_W-1:0] = ae_ofs[LO_W-1:0];
                OFS_AE_HI: s_d.dout[HI_W-1:0] = ae_ofs[AW-1:LO_W];
                OFS_AF_LO: s_d.dout[LO_W-1:0] = af_ofs[LO_W-1:0];
                default:   s_d.dout[HI_W-1:0] = af_ofs[AW-1:LO_W];
            endcase
            s_d.sel = ofs_sel_e'(s_q.sel + 2'd1);
        end
    end

    always_ff @(posedge rclk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= RD_RST;
        end else begin
            s_q <= s_d;
        end
    end

    assign mem_raddr = s_q.rbin[AW-1:0];
    assign rgray     = s_q.rgray;
    assign empty     = s_q.empty;
    assign pae       = s_q.pae;
    assign dout      = s_q.dout;
endmodule

// File: rtl/prog_flag_fifo.sv
`timescale 1ns/1ps
module prog_flag_fifo #(
    parameter int DATA_W      = 9,
    parameter int ADDR_W      = 5,
    parameter int OFS_LO_W    = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic              wclk,
    input  logic              rclk,
    input  logic              rst_n,
    input  logic              wen_n,
    input  logic              ren_n,
    input  logic              ld_n,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              empty_n,
    output logic              full_n,
    output logic              pae_n,
    output logic              paf_n
);
    localparam int PW = ADDR_W + 1;

    logic [PW-1:0]     wgray_w, rgray_w, wgray_s, rgray_s;
    logic              mem_we, full, paf, empty, pae;
    logic [ADDR_W-1:0] mem_waddr, mem_raddr, ae_ofs, af_ofs;
    logic [DATA_W-1:0] mem_rdata;

    fifo_wr_ctl #(.AW(ADDR_W), .DW(DATA_W), .LO_W(OFS_LO_W)) u_wr (
        .wclk      (wclk),
        .rst_n     (rst_n),
        .wen_n     (wen_n),
        .ld_n      (ld_n),
        .din       (din),
        .rgray_s   (rgray_s),
        .mem_we    (mem_we),
        .mem_waddr (mem_waddr),
        .wgray     (wgray_w),
        .full      (full),
        .paf       (paf),
        .ae_ofs    (ae_ofs),
        .af_ofs    (af_ofs)
    );

    fifo_rd_ctl #(.AW(ADDR_W), .DW(DATA_W), .LO_W(OFS_LO_W)) u_rd (
        .rclk      (rclk),
        .rst_n     (rst_n),
        .ren_n     (ren_n),
        .ld_n      (ld_n),
        .wgray_s   (wgray_s),
        .mem_rdata (mem_rdata),
        .ae_ofs    (ae_ofs),
        .af_ofs    (af_ofs),
        .mem_raddr (mem_raddr),
        .rgray     (rgray_w),
        .empty     (empty),
        .pae       (pae),
        .dout      (dout)
    );

    fifo_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_w2r (
        .clk   (rclk),
        .rst_n (rst_n),
        .d     (wgray_w),
        .q     (wgray_s)
    );

    fifo_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_r2w (
        .clk   (wclk),
        .rst_n (rst_n),
        .d     (rgray_w),
        .q     (rgray_s)
    );

    fifo_ram #(.AW(ADDR_W), .DW(DATA_W)) u_ram (
        .wclk  (wclk),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (din),
        .raddr (mem_raddr),
        .rdata (mem_rdata)
    );

    assign empty_n = ~empty;
    assign full_n  = ~full;
    assign pae_n   = ~pae;
    assign paf_n   = ~paf;
endmodule

// File: rtl/prog_flag_fifo_chk.sv
`timescale 1ns/1ps
module prog_flag_fifo_chk #(
    parameter int AW = 5,
    parameter int DW = 9
) (
    input logic          wclk,
    input logic          rclk,
    input logic          rst_n,
    input logic          wen_n,
    input logic          ren_n,
    input logic          ld_n,
    input logic          empty_n,
    input logic          full_n,
    input logic          pae_n,
    input logic          paf_n,
    input logic [AW:0]   wgray,
    input logic [AW:0]   rgray,
    input logic [DW-1:0] dout
);
    a_r3_no_overflow: assert property (@(posedge wclk) disable iff (!rst_n)
        (ld_n && !wen_n && !full_n) |=> $stable(wgray))
        else $error("R3: write pointer moved on a full write");

    a_r4_no_underflow: assert property (@(posedge rclk) disable iff (!rst_n)
        (ld_n && !ren_n && !empty_n) |=> ($stable(rgray) && $stable(dout)))
        else $error("R4: read side changed on an empty read");

    a_r7_load_no_push: assert property (@(posedge wclk) disable iff (!rst_n)
        (!ld_n && !wen_n) |=> $stable(wgray))
        else $error("R7: threshold load advanced the queue");

    a_r9_full_implies_paf: assert property (@(posedge wclk) disable iff (!rst_n)
        !full_n |-> !paf_n)
        else $error("R9: full without almost-full");

    a_r10_empty_implies_pae: assert property (@(posedge rclk) disable iff (!rst_n)
        !empty_n |-> !pae_n)
        else $error("R10: empty without almost-empty");

    a_r2_wgray_step: assert property (@(posedge wclk) disable iff (!rst_n)
        $countones(wgray ^ $past(wgray)) <= 1)
        else $error("R2: write pointer code moved more than one bit");

    a_r2_rgray_step: assert property (@(posedge rclk) disable iff (!rst_n)
        $countones(rgray ^ $past(rgray)) <= 1)
        else $error("R2: read pointer code moved more than one bit");
endmodule

bind prog_flag_fifo prog_flag_fifo_chk #(.AW(ADDR_W), .DW(DATA_W)) u_chk (
    .wclk    (wclk),
    .rclk    (rclk),
    .rst_n   (rst_n),
    .wen_n   (wen_n),
    .ren_n   (ren_n),
    .ld_n    (ld_n),
    .empty_n (empty_n),
    .full_n  (full_n),
    .pae_n   (pae_n),
    .paf_n   (paf_n),
    .wgray   (wgray_w),
    .rgray   (rgray_w),
    .dout    (dout)
);

// File: tb/prog_flag_fifo_test.sv
`timescale 1ns/1ps
module prog_flag_fifo_test;
    localparam int DW    = 9;
    localparam int AW    = 5;
    localparam int DEPTH = 1 << AW;
    localparam int N_AE  = 10;  // empty offset loaded below
    localparam int M_AF  = 14;  // full offset loaded below

    logic          wclk = 1'b0, rclk = 1'b0, rst_n = 1'b0;
    logic          wen_n = 1'b1, ren_n = 1'b1, ld_n = 1'b1;
    logic [DW-1:0] din = '0;
    logic [DW-1:0] dout;
    logic          empty_n, full_n, pae_n, paf_n;

    int            n_checks = 0, n_err = 0, pops = 0;
    bit            pend = 1'b0, done = 1'b0;
    logic [DW-1:0] exp_q [$];

    prog_flag_fifo uut (
        .wclk(wclk), .rclk(rclk), .rst_n(rst_n),
        .wen_n(wen_n), .ren_n(ren_n), .ld_n(ld_n),
        .din(din), .dout(dout),
        .empty_n(empty_n), .full_n(full_n), .pae_n(pae_n), .paf_n(paf_n)
    );

    // 250 MHz write clock; read clock of the same rate, offset by 1 ns.
    always #2 wclk = ~wclk;
    initial begin
        #3;
        forever begin
            rclk = 1'b1; #2;
            rclk = 1'b0; #2;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge rclk);
        #0.5;
    endtask

    // Scoreboard monitor: compares every accepted read (R2).
    initial forever begin
        @(negedge rclk);
        #0.5;
        if (pend) begin
            pops++;
            if (exp_q.size() == 0) check("R2 unexpected word", int'(dout), -1);
            else check("R2 order", int'(dout), int'(exp_q.pop_front()));
        end
        pend = !ren_n && ld_n && empty_n;
    end

    task automatic wr_field(input logic [DW-1:0] v);
        @(negedge wclk);
        ld_n = 1'b0; wen_n = 1'b0; din = v;
    endtask

    task automatic wr_stop();
        @(negedge wclk);
        wen_n = 1'b1; ld_n = 1'b1;
    endtask

    task automatic push_word(input logic [DW-1:0] v);
        bit ok = 1'b0;
        while (!ok) begin
            @(negedge wclk);
            ld_n = 1'b1; din = v;
            if (full_n) begin
                wen_n = 1'b0; exp_q.push_back(v); ok = 1'b1;
            end else begin
                wen_n = 1'b1;
            end
        end
    endtask

    task automatic read_words(input int n, input int gap);
        int issued = 0, cyc = 0;
        while (issued < n) begin
            @(negedge rclk);
            ld_n = 1'b1;
            if (cyc % gap == 0) begin
                ren_n = 1'b0;
                if (empty_n) issued++;
            end else begin
                ren_n = 1'b1;
            end
            cyc++;
        end
        @(negedge rclk);
        ren_n = 1'b1;
    endtask

    task automatic write_stream(input int n, input int gap, input int seed);
        int issued = 0, cyc = 0;
        while (issued < n) begin
            @(negedge wclk);
            ld_n = 1'b1;
            din = DW'(seed + issued * 11);
            if (cyc % gap == 0 && full_n) begin
                wen_n = 1'b0; exp_q.push_back(din); issued++;
            end else begin
                wen_n = 1'b1;
            end
            cyc++;
        end
        wr_stop();
    endtask

    task automatic peek_part(input string req, input int exp);
        @(negedge rclk);
        ld_n = 1'b0; ren_n = 1'b0;
        @(negedge rclk);
        ren_n = 1'b1; ld_n = 1'b1;
        #0.5;
        check(req, int'(dout), exp);
    endtask

    task automatic check_flags(input int cnt);
        check("R6 empty_n level", int'(empty_n), (cnt == 0) ? 0 : 1);
        check("R5 full_n level", int'(full_n), (cnt == DEPTH) ? 0 : 1);
        check("R10 pae_n level", int'(pae_n), (cnt <= N_AE) ? 0 : 1);
        check("R9 paf_n level", int'(paf_n), (cnt >= DEPTH - M_AF) ? 0 : 1);
    endtask

    initial begin
        #100000;
        if (!done) begin
            n_err++;
            n_checks++;
            $display("FAIL watchdog: actual 0 expected 1 (run completed)");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge wclk);
        #0.5;
        rst_n = 1'b1;
        settle(2);
        // R1: reset flag state
        check("R1 empty_n", int'(empty_n), 0);
        check("R1 pae_n", int'(pae_n), 0);
        check("R1 full_n", int'(full_n), 1);
        check("R1 paf_n", int'(paf_n), 1);
        // R1: thresholds cleared, read selector wraps back to start (R8)
        for (int i = 0; i < 4; i++) peek_part("R1 threshold cleared", 0);

        // R7: eight field writes, selector wraps; final n=10, m=14
        wr_field(9'd7); wr_field(9'd3); wr_field(9'd7); wr_field(9'd3);
        wr_field(9'd2); wr_field(9'd1); wr_field(9'd6); wr_field(9'd1);
        wr_stop();
        settle(6);
        check("R7 load leaves queue empty", int'(empty_n), 0);
        check("R7 load leaves full_n high", int'(full_n), 1);
        // R8: readback in order, twice to prove the wrap
        for (int r = 0; r < 2; r++) begin
            peek_part("R8 ae low", 2);
            peek_part("R8 ae high", 1);
            peek_part("R8 af low", 6);
            peek_part("R8 af high", 1);
        end

        // R4: reads on an empty FIFO change nothing
        @(negedge rclk);
        ren_n = 1'b0; ld_n = 1'b1;
        settle(3);
        check("R4 dout held on empty read", int'(dout), 1);
        @(negedge rclk);
        ren_n = 1'b1;

        // R6: first word not visible at the next read edge
        push_word(9'h155);
        wr_stop();
        @(negedge rclk);
        #0.5;
        check("R6 empty_n still low", int'(empty_n), 0);
        read_words(1, 1);
        settle(4);
        check("R6 first word taken", pops, 1);

        // Pattern A: fill step by step, check every level (R5 R9 R10)
        for (int k = 1; k <= DEPTH; k++) begin
            push_word(DW'(k * 37 + 5));
            wr_stop();
            settle(6);
            check_flags(k);
        end
        // R3: write into a full FIFO is dropped
        @(negedge wclk);
        ld_n = 1'b1; wen_n = 1'b0; din = 9'h1AA;
        wr_stop();
        settle(6);
        check("R3 full_n stays low", int'(full_n), 0);
        // Drain step by step; paf_n must release (R9)
        for (int k = DEPTH - 1; k >= 0; k--) begin
            read_words(1, 1);
            settle(6);
            check_flags(k);
        end
        check("R3 dropped word absent", exp_q.size(), 0);

        // Pattern B: slow reader, writer held at full
        fork
            write_stream(70, 1, 3);
            read_words(70, 3);
        join
        settle(8);
        // Pattern C: slow writer, reader at the empty edge
        fork
            write_stream(50, 2, 200);
            read_words(50, 1);
        join
        settle(8);
        check("R2 all words delivered", exp_q.size(), 0);
        check("R2 pop count", pops, 1 + 2 * DEPTH - DEPTH + 70 + 50);
        check_flags(0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end
endmodule